// File: doc/BRIEF.md
# External Bus Cycle Controller

This block is the master end of an external memory bus with asynchronous-style termination. An internal requester hands it one access at a time: a 24-bit address, an operand size (byte, word or longword), a direction, and write data. The controller runs that access on the pins. It drives the address, the active-low byte-lane strobes, an active-low read output enable and the chip selects, and it steers data onto the 32-bit data path. It then waits for the active-low transfer acknowledge before it captures read data or ends the write.

A small table of address windows chooses the chip select and the port width of the device behind it. When an operand is wider than its port, the controller splits the access into several bus beats. Each beat is terminated by its own acknowledge. An address that falls in no window gets a 32-bit port with no chip select. The requester sees a ready/done handshake, and read data appears right-justified when done pulses.

Top module: `ext_bus_ctrl`

## Requirements
- R1: While reset is held and in the first cycle after it, `req_ready`=1, `rsp_done`=0, `bus_addr`=0, `bus_bs_n`=4'hF, `bus_oe_n`=1, `bus_doe`=0, `bus_dout`=0 and every `bus_cs_n` bit is 1.
- R2: A request is taken at a rising edge where `req_valid` and `req_ready` are both 1. `req_ready` then stays 0 until the final beat is acknowledged. In the cycle after that acknowledge, `rsp_done` is 1 for exactly one cycle and `req_ready` is 1 again.
- R3: Each beat starts with one address cycle, in which the address, chip select and write drive are valid and the strobes are all high. A strobe phase follows and lasts until `bus_ta_n` is sampled low at a rising edge. An acknowledge during the address cycle is ignored. With `bus_ta_n` held low, an access of N beats raises `rsp_done` 2N cycles after the accepting edge.
- R4: `bus_oe_n` is 0 only during the strobe phase of a read, and never during a write.
- R5: `bus_doe` is 1 in every cycle of a write beat, covering both the address and strobe phases. It is 0 in every other cycle. When `bus_doe` is 1, all 32 lines are driven.
- R6: Operand byte j (j=0 being the most significant) lives at address A+j. It travels on lane 3-((A+j) mod 4) for a 32-bit port, on lane 3-((A+j) mod 2) for a 16-bit port, and on lane 3 for an 8-bit port. Lane k is data bits [8k+7:8k]. During a strobe phase, `bus_bs_n[k]` is 0 exactly for the lanes of the bytes in that beat.
- R7: On a write, each byte of the current beat appears on its lane of `bus_dout`. Lanes outside the beat carry zero. Write data is right-justified: for a size of S bytes, byte j is `req_wdata[8(S-1-j)+7 : 8(S-1-j)]`.
- R8: On a read, the bytes on the strobed lanes of `bus_din` are captured at each acknowledging edge. Bytes on other lanes have no effect. When `rsp_done` pulses, `rsp_rdata` holds the operand right-justified with zero upper bytes.
- R9: An operand of S bytes on a port of P bytes takes max(1, S/P) beats. Beat b drives `bus_addr` = A + b·P.
- R10: Window i matches when `cfg_cs_en[i]`=1 and the address agrees with `cfg_cs_base` under `cfg_cs_mask`. The lowest matching index wins. The chosen `bus_cs_n[i]` is 0 during the address and strobe phases of the access, and the chip selects are all 1 otherwise.
- R11: An address that matches no enabled window uses a 32-bit port and leaves every chip select high.
- R12: The 2-bit width code per window is 00=32-bit, 01=8-bit, 10=16-bit, 11=32-bit. The size code is 00=byte, 01=word, 10=longword.
- R13: Changes to the request inputs while `req_ready` is 0 have no effect on the access in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, can take a request |
| req_addr | input | 24 | Byte address of the access |
| req_size | input | 2 | Operand size code |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 32 | Right-justified write operand |
| rsp_done | output | 1 | One-cycle pulse when the access completes |
| rsp_rdata | output | 32 | Right-justified read operand |
| cfg_cs_en | input | NUM_CS | Window enables |
| cfg_cs_base | input | NUM_CS*24 | Window base addresses, window i at bits [24i+23:24i] |
| cfg_cs_mask | input | NUM_CS*24 | Window compare masks |
| cfg_cs_width | input | NUM_CS*2 | Window port width codes |
| bus_addr | output | 24 | External address |
| bus_dout | output | 32 | Data driven onto the bus |
| bus_doe | output | 1 | Data driver enable (high = drive) |
| bus_din | input | 32 | Data sampled from the bus |
| bus_bs_n | output | 4 | Active-low byte-lane strobes |
| bus_oe_n | output | 1 | Active-low read output enable |
| bus_ta_n | input | 1 | Active-low transfer acknowledge |
| bus_cs_n | output | NUM_CS | Active-low chip selects |

## Verification
The assertions take the requester to issue only aligned accesses with a defined size code, and to keep the window configuration steady while an access is running. They also take `bus_ta_n` to be a clean synchronous level. The stimulus only offers aligned offsets for each size and only changes the window table between accesses. It drives the acknowledge at the falling edge. While the controller is busy, it deliberately scrambles the request inputs. This exercises the ignore rule without breaking those assumptions, because the scrambled values are withdrawn before the edge at which the controller becomes ready again.

// File: rtl/ebc_pkg.sv
package ebc_pkg;

    localparam int ADDR_W = 24;
    localparam int DATA_W = 32;
    localparam int NLANES = DATA_W / 8;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'b00,
        SZ_WORD = 2'b01,
        SZ_LONG = 2'b10,
        SZ_RSVD = 2'b11
    } size_e;

    typedef enum logic [1:0] {
        PW_32  = 2'b00,
        PW_8   = 2'b01,
        PW_16  = 2'b10,
        PW_32X = 2'b11
    } pw_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_ADDR = 2'b01,
        ST_STRB = 2'b10
    } state_e;

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
        size_e             size;
        logic              write;
        logic [DATA_W-1:0] wdata;
        pw_e               width;
    } xfer_t;

    // log2 of operand bytes
    function automatic logic [1:0] size_log2(size_e s);
        case (s)
            SZ_BYTE: return 2'd0;
            SZ_WORD: return 2'd1;
            default: return 2'd2;
        endcase
    endfunction

    // log2 of port bytes
    function automatic logic [1:0] port_log2(pw_e w);
        case (w)
            PW_8:    return 2'd0;
            PW_16:   return 2'd1;
            default: return 2'd2;
        endcase
    endfunction

    // index of the final beat of an access
    function automatic logic [1:0] last_beat(size_e s, pw_e w);
        logic [1:0] sl;
        logic [1:0] pl;
        sl = size_log2(s);
        pl = port_log2(w);
        if (sl > pl) begin
            return 2'((3'd1 << (sl - pl)) - 3'd1);
        end
        return 2'd0;
    endfunction

    // byte lane for an address offset, big-endian lane order
    function automatic logic [1:0] lane_of(logic [1:0] off, pw_e w);
        case (w)
            PW_8:    return 2'd3;
            PW_16:   return off[0] ? 2'd2 : 2'd3;
            default: return ~off;
        endcase
    endfunction

endpackage

// File: rtl/ebc_cs_decode.sv
module ebc_cs_decode
    import ebc_pkg::*;
#(
    parameter int NUM_CS = 2,
    parameter int AW     = ADDR_W
) (
    input  logic [AW-1:0]        addr,
    input  logic [NUM_CS-1:0]    cs_en,
    input  logic [NUM_CS*AW-1:0] cs_base,
    input  logic [NUM_CS*AW-1:0] cs_mask,
    input  logic [NUM_CS*2-1:0]  cs_width,
    output logic [NUM_CS-1:0]    sel,
    output pw_e                  width
);

    logic [NUM_CS-1:0] match;

    for (genvar g = 0; g < NUM_CS; g++) begin : g_win
        assign match[g] = cs_en[g] &&
            (((addr ^ cs_base[g*AW +: AW]) & cs_mask[g*AW +: AW]) == '0);
    end

    // lowest index wins: scan from the top so lower indices overwrite
    always_comb begin
        sel   = '0;
        width = PW_32;
        for (int i = NUM_CS - 1; i >= 0; i--) begin
            if (match[i]) begin
                sel    = '0;
                sel[i] = 1'b1;
                width  = pw_e'(cs_width[2*i +: 2]);
            end
        end
    end

endmodule

// File: rtl/ebc_lanes.sv
module ebc_lanes
    import ebc_pkg::*;
(
    input  logic [1:0]        off,
    input  size_e             size,
    input  pw_e               width,
    input  logic [1:0]        beat,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] din,
    input  logic [DATA_W-1:0] racc,
    output logic [NLANES-1:0] lane_en,
    output logic [DATA_W-1:0] dout,
    output logic [DATA_W-1:0] rnext
);

    always_comb begin
        logic [1:0] sl;
        logic [1:0] pl;
        logic [1:0] jj;
        logic [1:0] lane;
        logic [1:0] opos;
        logic       in_size;
        logic       in_beat;

        lane_en = '0;
        dout    = '0;
        rnext   = racc;
        sl      = size_log2(size);
        pl      = port_log2(width);
        jj      = '0;
        lane    = '0;
        opos    = '0;
        in_size = 1'b0;
        in_beat = 1'b0;

        for (int j = 0; j < NLANES; j++) begin
            jj      = 2'(j);
            in_size = (3'(j) < (3'd1 << sl));
            in_beat = ((jj >> pl) == beat);
            lane    = lane_of(off + jj, width);
            opos    = 2'((3'd1 << sl) - 3'd1 - 3'(j));
            if (in_size && in_beat) begin
                lane_en[lane]        = 1'b1;
                dout[8*lane +: 8]    = wdata[8*opos +: 8];
                rnext[8*opos +: 8]   = din[8*lane +: 8];
            end
        end
    end

endmodule

// File: rtl/ebc_seq.sv
module ebc_seq
    import ebc_pkg::*;
#(
    parameter int NUM_CS = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  xfer_t             req_xfer,
    input  logic [NUM_CS-1:0] req_sel,
    input  logic              ack_n,
    input  logic [DATA_W-1:0] rdata_next,
    output logic              ready,
    output logic              done,
    output logic              addr_phase,
    output logic              strb_phase,
    output xfer_t             cur,
    output logic [NUM_CS-1:0] cur_sel,
    output logic [1:0]        beat,
    output logic [DATA_W-1:0] racc
);

    state_e     state_q;
    logic [1:0] final_beat;

    assign final_beat = last_beat(cur.size, cur.width);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            done    <= 1'b0;
            cur     <= '0;
            cur_sel <= '0;
            beat    <= '0;
            racc    <= '0;
        end else begin
            done <= 1'b0;
            unique case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        cur     <= req_xfer;
                        cur_sel <= req_sel;
                        beat    <= '0;
                        racc    <= '0;
                        state_q <= ST_ADDR;
                    end
                end
                ST_ADDR: begin
                    state_q <= ST_STRB;
                end
                ST_STRB: begin
                    if (!ack_n) begin
                        if (!cur.write) begin
                            racc <= rdata_next;
                        end
                        if (beat == final_beat) begin
                            state_q <= ST_IDLE;
                            done    <= 1'b1;
                        end else begin
                            beat    <= beat + 2'd1;
                            state_q <= ST_ADDR;
                        end
                    end
                end
                default: begin
                    state_q <= ST_IDLE;
                end
            endcase
        end
    end

    assign ready      = (state_q == ST_IDLE);
    assign addr_phase = (state_q == ST_ADDR);
    assign strb_phase = (state_q == ST_STRB);

endmodule

// File: rtl/ext_bus_ctrl.sv
module ext_bus_ctrl
    import ebc_pkg::*;
#(
    parameter int NUM_CS = 2
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     req_valid,
    output logic                     req_ready,
    input  logic [ADDR_W-1:0]        req_addr,
    input  logic [1:0]               req_size,
    input  logic                     req_write,
    input  logic [DATA_W-1:0]        req_wdata,
    output logic                     rsp_done,
    output logic [DATA_W-1:0]        rsp_rdata,
    input  logic [NUM_CS-1:0]        cfg_cs_en,
    input  logic [NUM_CS*ADDR_W-1:0] cfg_cs_base,
    input  logic [NUM_CS*ADDR_W-1:0] cfg_cs_mask,
    input  logic [NUM_CS*2-1:0]      cfg_cs_width,
    output logic [ADDR_W-1:0]        bus_addr,
    output logic [DATA_W-1:0]        bus_dout,
    output logic                     bus_doe,
    input  logic [DATA_W-1:0]        bus_din,
    output logic [NLANES-1:0]        bus_bs_n,
    output logic                     bus_oe_n,
    input  logic                     bus_ta_n,
    output logic [NUM_CS-1:0]        bus_cs_n
);

    pw_e               dec_width;
    logic [NUM_CS-1:0] dec_sel;
    xfer_t             req_x;
    xfer_t             cur;
    logic [NUM_CS-1:0] cur_sel;
    logic [1:0]        beat;
    logic [DATA_W-1:0] racc;
    logic [DATA_W-1:0] rnext;
    logic [DATA_W-1:0] drive;
    logic [NLANES-1:0] lane_en;
    logic              addr_phase;
    logic              strb_phase;
    logic              active;
    logic [ADDR_W-1:0] beat_addr;

    ebc_cs_decode #(
        .NUM_CS (NUM_CS),
        .AW     (ADDR_W)
    ) u_dec (
        .addr     (req_addr),
        .cs_en    (cfg_cs_en),
        .cs_base  (cfg_cs_base),
        .cs_mask  (cfg_cs_mask),
        .cs_width (cfg_cs_width),
        .sel      (dec_sel),
        .width    (dec_width)
    );

    always_comb begin
        req_x.addr  = req_addr;
        req_x.size  = size_e'(req_size);
        req_x.write = req_write;
        req_x.wdata = req_wdata;
        req_x.width = dec_width;
    end

    ebc_seq #(
        .NUM_CS (NUM_CS)
    ) u_seq (
        .clk        (clk),
        .rst        (rst),
        .req_valid  (req_valid),
        .req_xfer   (req_x),
        .req_sel    (dec_sel),
        .ack_n      (bus_ta_n),
        .rdata_next (rnext),
        .ready      (req_ready),
        .done       (rsp_done),
        .addr_phase (addr_phase),
        .strb_phase (strb_phase),
        .cur        (cur),
        .cur_sel    (cur_sel),
        .beat       (beat),
        .racc       (racc)
    );

    ebc_lanes u_lanes (
        .off     (cur.addr[1:0]),
        .size    (cur.size),
        .width   (cur.width),
        .beat    (beat),
        .wdata   (cur.wdata),
        .din     (bus_din),
        .racc    (racc),
        .lane_en (lane_en),
        .dout    (drive),
        .rnext   (rnext)
    );

    assign active    = addr_phase || strb_phase;
    assign beat_addr = cur.addr + (ADDR_W'(beat) << port_log2(cur.width));

    assign bus_addr  = active ? beat_addr : '0;
    assign bus_bs_n  = strb_phase ? ~lane_en : '1;
    assign bus_oe_n  = !(strb_phase && !cur.write);
    assign bus_doe   = active && cur.write;
    assign bus_dout  = bus_doe ? drive : '0;
    assign bus_cs_n  = active ? ~cur_sel : '1;
    assign rsp_rdata = racc;

endmodule

// File: rtl/ebc_chk.sv
module ebc_chk #(
    parameter int NUM_CS = 2
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_ready,
    input logic              rsp_done,
    input logic [23:0]       bus_addr,
    input logic [3:0]        bus_bs_n,
    input logic              bus_oe_n,
    input logic              bus_doe,
    input logic              bus_ta_n,
    input logic [NUM_CS-1:0] bus_cs_n
);

    p_oe_not_driving_r4: assert property (@(posedge clk) disable iff (rst)
        !bus_oe_n |-> !bus_doe);

    p_oe_needs_strobe_r4: assert property (@(posedge clk) disable iff (rst)
        !bus_oe_n |-> (bus_bs_n != 4'hF));

    p_busy_after_take_r2: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);

    p_done_when_ready_r2: assert property (@(posedge clk) disable iff (rst)
        rsp_done |-> req_ready);

    p_done_single_r2: assert property (@(posedge clk) disable iff (rst)
        rsp_done |=> !rsp_done);

    p_addr_cycle_first_r3: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> (bus_bs_n == 4'hF));

    p_hold_until_ack_r3: assert property (@(posedge clk) disable iff (rst)
        ((bus_bs_n != 4'hF) && bus_ta_n) |=>
            ($stable(bus_addr) && $stable(bus_bs_n) && $stable(bus_oe_n)));

    p_idle_quiet_r5: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> ((bus_bs_n == 4'hF) && !bus_doe && bus_oe_n));

    p_one_select_r10: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~bus_cs_n));

endmodule

bind ext_bus_ctrl ebc_chk #(.NUM_CS(NUM_CS)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .rsp_done  (rsp_done),
    .bus_addr  (bus_addr),
    .bus_bs_n  (bus_bs_n),
    .bus_oe_n  (bus_oe_n),
    .bus_doe   (bus_doe),
    .bus_ta_n  (bus_ta_n),
    .bus_cs_n  (bus_cs_n)
);

// File: tb/ext_bus_ctrl_tb.sv
module ext_bus_ctrl_tb;

    localparam int NCS = 2;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [23:0]       req_addr = '0;
    logic [1:0]        req_size = '0;
    logic              req_write = 1'b0;
    logic [31:0]       req_wdata = '0;
    logic              rsp_done;
    logic [31:0]       rsp_rdata;
    logic [NCS-1:0]    cfg_cs_en = '0;
    logic [NCS*24-1:0] cfg_cs_base = '0;
    logic [NCS*24-1:0] cfg_cs_mask = '0;
    logic [NCS*2-1:0]  cfg_cs_width = '0;
    logic [23:0]       bus_addr;
    logic [31:0]       bus_dout;
    logic              bus_doe;
    logic [31:0]       bus_din = '0;
    logic [3:0]        bus_bs_n;
    logic              bus_oe_n;
    logic              bus_ta_n = 1'b1;
    logic [NCS-1:0]    bus_cs_n;

    int n_checks = 0;
    int n_err    = 0;
    int n_xfer   = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    ext_bus_ctrl #(.NUM_CS(NCS)) u_dut (
        .clk          (clk),
        .rst          (rst),
        .req_valid    (req_valid),
        .req_ready    (req_ready),
        .req_addr     (req_addr),
        .req_size     (req_size),
        .req_write    (req_write),
        .req_wdata    (req_wdata),
        .rsp_done     (rsp_done),
        .rsp_rdata    (rsp_rdata),
        .cfg_cs_en    (cfg_cs_en),
        .cfg_cs_base  (cfg_cs_base),
        .cfg_cs_mask  (cfg_cs_mask),
        .cfg_cs_width (cfg_cs_width),
        .bus_addr     (bus_addr),
        .bus_dout     (bus_dout),
        .bus_doe      (bus_doe),
        .bus_din      (bus_din),
        .bus_bs_n     (bus_bs_n),
        .bus_oe_n     (bus_oe_n),
        .bus_ta_n     (bus_ta_n),
        .bus_cs_n     (bus_cs_n)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] mem_byte(logic [23:0] x);
        return 8'(x[7:0] * 8'd37 + 8'd5);
    endfunction

    function automatic int lane_for(logic [23:0] x, int pb);
        if (pb == 4) return 3 - int'(x[1:0]);
        if (pb == 2) return 3 - int'(x[0]);
        return 3;
    endfunction

    task automatic do_xfer(input logic [23:0] ad, input int sb, input bit wr,
                           input logic [31:0] wd, input int pb,
                           input logic [NCS-1:0] exp_cs, input int waits,
                           input string rtag);
        int          nb;
        logic [31:0] exp_rd;
        logic [3:0]  exp_bs;
        logic [31:0] exp_do;
        logic [31:0] din_v;
        logic [23:0] ba;
        nb     = (sb > pb) ? sb / pb : 1;
        exp_rd = '0;
        n_xfer++;

        @(negedge clk);
        chk("R2", "ready before request", 32'(req_ready), 32'd1);
        req_valid = 1'b1;
        req_addr  = ad;
        req_size  = (sb == 1) ? 2'b00 : (sb == 2) ? 2'b01 : 2'b10;
        req_write = wr;
        req_wdata = wd;

        for (int b = 0; b < nb; b++) begin
            @(negedge clk);
            if (b == 0) begin
                // scramble the request while busy (R13)
                req_addr  = ad ^ 24'h5A5A5A;
                req_size  = 2'b10;
                req_write = !wr;
                req_wdata = ~wd;
            end
            ba = ad + 24'(b * pb);
            chk("R9", "beat address", 32'(bus_addr), 32'(ba));
            chk("R3", "strobes off in address cycle", 32'(bus_bs_n), 32'hF);
            chk("R4", "oe in address cycle", 32'(bus_oe_n), 32'd1);
            chk("R5", "drive in address cycle", 32'(bus_doe), 32'(wr));
            chk({"R10 ", rtag}, "chip select", 32'(bus_cs_n), 32'(exp_cs));
            chk("R2", "busy", 32'(req_ready), 32'd0);

            exp_bs = 4'hF;
            exp_do = '0;
            din_v  = 32'hC3C3C3C3;
            for (int j = 0; j < sb; j++) begin
                if (j / pb == b || sb <= pb) begin
                    int          ln;
                    logic [23:0] xa;
                    xa = ad + 24'(j);
                    ln = lane_for(xa, pb);
                    exp_bs[ln]       = 1'b0;
                    exp_do[8*ln +: 8] = wd[8*(sb-1-j) +: 8];
                    din_v[8*ln +: 8]  = mem_byte(xa);
                    exp_rd[8*(sb-1-j) +: 8] = mem_byte(xa);
                end
            end
            bus_din  = din_v;
            bus_ta_n = 1'b0;   // acknowledge during address cycle must be ignored (R3)

            for (int w = 0; w <= waits; w++) begin
                @(negedge clk);
                chk({"R6 ", rtag}, "strobes", 32'(bus_bs_n), 32'(exp_bs));
                chk("R4", "oe in strobe phase", 32'(bus_oe_n), 32'(wr));
                chk("R5", "drive in strobe phase", 32'(bus_doe), 32'(wr));
                chk("R13", "address held", 32'(bus_addr), 32'(ba));
                if (wr) chk("R7", "write lanes", bus_dout, exp_do);
                if (w > 0) chk("R3", "held while no ack", 32'(req_ready), 32'd0);
                bus_ta_n = (w == waits) ? 1'b0 : 1'b1;
            end
        end

        @(negedge clk);
        req_valid = 1'b0;
        chk("R2", "done pulse", 32'(rsp_done), 32'd1);
        chk("R2", "ready at done", 32'(req_ready), 32'd1);
        chk("R3", "bus idle at done", {bus_bs_n, 3'b0, bus_oe_n, 3'b0, bus_doe,
            20'(bus_cs_n)}, {4'hF, 3'b0, 1'b1, 3'b0, 1'b0, 20'(2**NCS - 1)});
        if (!wr) chk("R8", "read operand", rsp_rdata, exp_rd);
        @(negedge clk);
        chk("R2", "done is one cycle", 32'(rsp_done), 32'd0);
        chk("R13", "no second access", 32'(req_ready), 32'd1);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_err++;
            $display("FAIL R2 watchdog expired: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] wd;
        int          pb;

        cfg_cs_en    = 2'b01;
        cfg_cs_base  = {24'h200000, 24'h100000};
        cfg_cs_mask  = {24'hF00000, 24'hF00000};
        cfg_cs_width = 4'b0000;

        repeat (3) @(negedge clk);
        chk("R1", "ready in reset", 32'(req_ready), 32'd1);
        chk("R1", "strobes in reset", 32'(bus_bs_n), 32'hF);
        chk("R1", "oe in reset", 32'(bus_oe_n), 32'd1);
        chk("R1", "drive in reset", {31'd0, bus_doe}, 32'd0);
        chk("R1", "cs in reset", 32'(bus_cs_n), 32'(2**NCS - 1));
        chk("R1", "addr in reset", 32'(bus_addr), 32'd0);
        chk("R1", "dout in reset", bus_dout, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1", "done after reset", 32'(rsp_done), 32'd0);
        chk("R1", "strobes after reset", 32'(bus_bs_n), 32'hF);
        bus_ta_n = 1'b0;

        // full sweep: every width code, size, aligned offset and direction
        for (int wc = 0; wc < 4; wc++) begin
            cfg_cs_width[1:0] = 2'(wc);
            pb = (wc == 1) ? 1 : (wc == 2) ? 2 : 4;
            for (int sl = 0; sl < 3; sl++) begin
                for (int off = 0; off < 4; off += (1 << sl)) begin
                    for (int wr = 0; wr < 2; wr++) begin
                        wd = 32'h1357_9BDF ^ (32'(n_xfer) * 32'h0111_0111);
                        do_xfer(24'h100040 + 24'(off), 1 << sl, wr[0], wd, pb,
                                2'b10, n_xfer % 3, "R12");
                    end
                end
            end
        end

        // no window matches: 32-bit port, no select
        cfg_cs_width = 4'b0101;
        do_xfer(24'h300008, 4, 1'b0, 32'h0, 4, 2'b11, 1, "R11");
        do_xfer(24'h300009, 1, 1'b1, 32'hFFFF_FF6C, 4, 2'b11, 0, "R11");
        do_xfer(24'h30000A, 2, 1'b0, 32'h0, 4, 2'b11, 2, "R11");

        // window disabled: falls back to the default
        cfg_cs_en = 2'b00;
        do_xfer(24'h100050, 4, 1'b1, 32'hA1B2_C3D4, 4, 2'b11, 0, "R11");

        // overlapping windows: lower index wins
        cfg_cs_en    = 2'b11;
        cfg_cs_base  = {24'h100000, 24'h100000};
        cfg_cs_width = 4'b0110;   // window1 8-bit, window0 16-bit
        do_xfer(24'h100060, 4, 1'b0, 32'h0, 2, 2'b10, 1, "R10");
        do_xfer(24'h100064, 4, 1'b1, 32'h0F1E_2D3C, 2, 2'b10, 0, "R10");
        cfg_cs_en = 2'b10;
        do_xfer(24'h100068, 4, 1'b0, 32'h0, 1, 2'b01, 0, "R10");
        do_xfer(24'h10006E, 2, 1'b1, 32'h0000_BEEF, 1, 2'b01, 2, "R10");

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
        $finish;
    end

endmodule